// File: doc/BRIEF.md
# LRU Bus Arbiter with External Release

This block decides which requester owns a shared local bus. Three internal masters compete for the bus. When more than one of them asks at once, the one that has waited longest since its last completed transaction wins. A separate external release request takes priority over all internal masters. When it is asserted, the arbiter gives the bus up at the next transaction boundary and answers with an acknowledge.

A transaction is one or more bus cycles. The bus controller reports the end of each cycle. It also reports two flags: one says the current cycle belongs to a split or burst sequence, and the other says it belongs to a locked read-modify-write. Ownership never moves while either flag is up. Before the bus passes to the external device, every bus control output is held at its inactive level for at least one clock. That negated phase also covers the single clock after the acknowledge drops, so the internal side starts driving again from the inactive level. When nothing is pending, the grant stays parked with the last owner.

Top module: `lru_bus_arbiter`

## Requirements
- R1: While reset is asserted, and on the first idle cycle after it, `grant_o`, `ext_ack_o` and `ctl_negate_o` are all 0. The initial ranking is master 0 first, then master 1, then master 2, so with all three requesting from reset, master 0 is granted.
- R2: Bit i of `grant_o` is master i's grant. At most one bit of `grant_o` is ever set.
- R3: Among simultaneous internal requests, the master highest in the ranking wins. A master that finishes a transaction drops to the lowest rank, and the others keep their relative order.
- R4: A grant holds through every cycle in which `cyc_end_i` is low, or `seq_i` is high, or `lock_i` is high. The transaction ends only at a clock where `cyc_end_i`=1, `seq_i`=0 and `lock_i`=0, even if an external request is pending.
- R5: External release starts at a transaction end, or at any clock when no transaction is running, if `ext_req_i` is high. On the next clock `grant_o`=0, `ctl_negate_o`=1 and `ext_ack_o`=0. On the clock after that, `ext_ack_o`=1 and `ctl_negate_o` stays 1.
- R6: `ext_ack_o` stays high while `ext_req_i` stays high. The clock after `ext_req_i` falls, `ext_ack_o`=0, `ctl_negate_o`=1 and `grant_o`=0. On the next clock a pending internal request is granted. With none pending, `grant_o` stays 0.
- R7: At a transaction end with no request pending, `grant_o` keeps the last owner's bit set and `ctl_negate_o`=0.
- R8: From idle or parked, an internal request is granted one clock after it is presented.
- R9: When the external request and internal requests arrive together at a boundary, the external request wins. The internal winner is granted one clock after the acknowledge drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 3 | Internal master requests, bit i for master i |
| ext_req_i | input | 1 | External bus release request |
| cyc_end_i | input | 1 | Current bus cycle ends this clock |
| seq_i | input | 1 | Current cycle is part of a split or burst sequence |
| lock_i | input | 1 | Current cycle is inside a locked read-modify-write |
| grant_o | output | 3 | One-hot internal grant, parked bit kept when idle |
| ext_ack_o | output | 1 | Bus handed to the external requester |
| ctl_negate_o | output | 1 | Force all bus control outputs to their inactive level |

## Verification
Several properties are checked on every clock: the grant is one-hot or zero, the ranking stays a permutation, a grant never moves mid-transaction, and the acknowledge rises only after a negated, grant-free clock. They also check that grant and acknowledge never overlap, and that the clock after the acknowledge falls is still negated with no grant. The bench scenarios cover behaviour that needs a reference model of the ranking. They check which master wins for every request pattern over several rounds of rotation, parking after a finished transaction, and that the grant is deferred until the boundary when the external request is asserted mid-sequence or mid-lock. They also check which internal master is granted once the external device returns the bus.

// File: rtl/lru_arb_pkg.sv
// Shared types for the LRU bus arbiter.
// Assumes: used by lru_release_fsm and lru_bus_arbiter only.
package lru_arb_pkg;

    // Ownership phases of the shared bus
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // no owner, no grant
        ST_PARK = 3'd1,  // last owner keeps grant, no transaction
        ST_OWN  = 3'd2,  // owner's transaction in progress
        ST_NEG  = 3'd3,  // controls negated before external hand-over
        ST_EXT  = 3'd4,  // bus held by external requester
        ST_RET  = 3'd5   // controls negated after external return
    } arb_state_t;

endpackage

// File: rtl/lru_rank.sv
// Least-recently-used ranking of internal masters.
// Holds an ordered list of master ids, with entry 0 ranked highest.
// A touch moves one id to the last place, and the rest close up in order.
// The winner is picked from the ranking after this cycle's touch, so a
// master that just finished loses ties on its immediate re-request.
// Assumes: N >= 2, and touch_id is a valid id when touch_en is set.
module lru_rank #(
    parameter int unsigned N   = 3,
    parameter int unsigned IDW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req,
    input  logic           touch_en,
    input  logic [IDW-1:0] touch_id,
    output logic           win_vld,
    output logic [IDW-1:0] win_id
);

    logic [IDW-1:0] order_q  [N];
    logic [IDW-1:0] order_nx [N];
    int unsigned    hit_pos;

    // Ranking after the optional touch: the touched id moves to the tail
    always_comb begin
        hit_pos = N - 1;
        for (int k = 0; k < N; k++) begin
            if (order_q[k] == touch_id) hit_pos = k;
        end
        for (int k = 0; k < N; k++) begin
            if (!touch_en || (k < hit_pos))
                order_nx[k] = order_q[k];
            else if (k == N - 1)
                order_nx[k] = touch_id;
            else
                order_nx[k] = order_q[(k + 1) % N];
        end
    end

    // Winner: the highest-ranked requesting id
    always_comb begin
        win_vld = 1'b0;
        win_id  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[order_nx[k]]) begin
                win_vld = 1'b1;
                win_id  = order_nx[k];
            end
        end
    end

    // Ranking register, reset to ascending id order
    always_ff @(posedge clk) begin
        for (int k = 0; k < N; k++) begin
            if (!rst_n) order_q[k] <= IDW'(k);
            else        order_q[k] <= order_nx[k];
        end
    end

    logic [N-1:0] seen_ids;

    // Set of ids present in the ranking, for the permutation check
    always_comb begin
        seen_ids = '0;
        for (int k = 0; k < N; k++) seen_ids = seen_ids | (N'(1) << order_q[k]);
    end

    AST_ORDER_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen_ids) == N) else $error("ranking not a permutation"); // R3

endmodule

// File: rtl/lru_release_fsm.sv
// Ownership controller. It tracks the phase of the bus and the current
// owner, ends transactions only at unflagged cycle ends, and sequences
// the negate, acknowledge and return phases for the external requester.
// Assumes: win_id is valid whenever req_any is set.
module lru_release_fsm
    import lru_arb_pkg::*;
#(
    parameter int unsigned N   = 3,
    parameter int unsigned IDW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_any,
    input  logic [IDW-1:0] win_id,
    input  logic           ext_req,
    input  logic           cyc_end,
    input  logic           seq_act,
    input  logic           lock_act,
    output logic [N-1:0]   grant,
    output logic           ext_ack,
    output logic           ctl_neg,
    output logic           touch_en,
    output logic [IDW-1:0] touch_id
);

    arb_state_t     state_q, state_nx;
    logic [IDW-1:0] owner_q, owner_nx;
    logic           tx_end;

    // A transaction ends on a cycle end outside any sequence or lock
    assign tx_end   = (state_q == ST_OWN) && cyc_end && !seq_act && !lock_act;
    assign touch_en = tx_end;
    assign touch_id = owner_q;

    // Next phase and owner
    always_comb begin
        state_nx = state_q;
        owner_nx = owner_q;
        case (state_q)
            ST_IDLE, ST_PARK, ST_RET: begin
                if (ext_req) begin
                    state_nx = ST_NEG;
                end else if (req_any) begin
                    state_nx = ST_OWN;
                    owner_nx = win_id;
                end else if (state_q == ST_RET) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_OWN: begin
                if (tx_end) begin
                    if (ext_req) begin
                        state_nx = ST_NEG;
                    end else if (req_any) begin
                        state_nx = ST_OWN;
                        owner_nx = win_id;
                    end else begin
                        state_nx = ST_PARK;
                    end
                end
            end
            ST_NEG:  state_nx = ST_EXT;
            ST_EXT:  state_nx = ext_req ? ST_EXT : ST_RET;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Phase and owner registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_nx;
            owner_q <= owner_nx;
        end
    end

    // Output decode from the registered phase
    always_comb begin
        grant   = ((state_q == ST_OWN) || (state_q == ST_PARK)) ? (N'(1) << owner_q) : '0;
        ext_ack = (state_q == ST_EXT);
        ctl_neg = (state_q == ST_NEG) || (state_q == ST_EXT) || (state_q == ST_RET);
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)) else $error("multiple grants"); // R2

    AST_HOLD_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWN && !(cyc_end && !seq_act && !lock_act))
        |=> (state_q == ST_OWN && $stable(owner_q))) else $error("grant moved mid-transaction"); // R4

    AST_NEG_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_ack) |-> ($past(ctl_neg) && ($past(grant) == '0))) else $error("ack without negate phase"); // R5

    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ack |-> (grant == '0 && ctl_neg)) else $error("ack overlaps grant"); // R5

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_ack && ext_req) |=> ext_ack) else $error("ack dropped early"); // R6

    AST_RETURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_ack) |-> (grant == '0 && ctl_neg)) else $error("no negated clock on return"); // R6

endmodule

// File: rtl/lru_bus_arbiter.sv
// Top of the LRU bus arbiter. It joins the ranking store to the ownership
// controller. The ranking is touched by the controller at each transaction
// end, and the ranking's winner feeds the controller's next-owner choice.
// Assumes: inputs are synchronous to clk.
module lru_bus_arbiter #(
    parameter int unsigned N_MASTERS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic                 ext_req_i,
    input  logic                 cyc_end_i,
    input  logic                 seq_i,
    input  logic                 lock_i,
    output logic [N_MASTERS-1:0] grant_o,
    output logic                 ext_ack_o,
    output logic                 ctl_negate_o
);

    localparam int unsigned IDW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

    logic           win_vld;
    logic [IDW-1:0] win_id;
    logic           touch_en;
    logic [IDW-1:0] touch_id;

    lru_rank #(.N(N_MASTERS), .IDW(IDW)) rank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_i),
        .touch_en (touch_en),
        .touch_id (touch_id),
        .win_vld  (win_vld),
        .win_id   (win_id)
    );

    lru_release_fsm #(.N(N_MASTERS), .IDW(IDW)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_any  (win_vld),
        .win_id   (win_id),
        .ext_req  (ext_req_i),
        .cyc_end  (cyc_end_i),
        .seq_act  (seq_i),
        .lock_act (lock_i),
        .grant    (grant_o),
        .ext_ack  (ext_ack_o),
        .ctl_neg  (ctl_negate_o),
        .touch_en (touch_en),
        .touch_id (touch_id)
    );

endmodule

// File: tb/lru_bus_arbiter_tb_top.sv
// Bench: sweeps every request pattern through several rotations of a
// reference ranking model, then runs the external release scenarios.
// Inputs change on the falling edge and outputs are sampled there too.
module lru_bus_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req_i = '0;
    logic       ext_req_i = 1'b0;
    logic       cyc_end_i = 1'b0;
    logic       seq_i = 1'b0;
    logic       lock_i = 1'b0;
    logic [2:0] grant_o;
    logic       ext_ack_o;
    logic       ctl_negate_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    int ord [3]  = '{0, 1, 2};

    always #5 clk = ~clk;

    lru_bus_arbiter #(.N_MASTERS(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ext_req_i(ext_req_i),
        .cyc_end_i(cyc_end_i), .seq_i(seq_i), .lock_i(lock_i),
        .grant_o(grant_o), .ext_ack_o(ext_ack_o), .ctl_negate_o(ctl_negate_o)
    );

    // Compare one value and report a mismatch
    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference winner: first ranked id with its request bit set
    function automatic int model_win(input int mask);
        for (int k = 0; k < 3; k++) if (mask[ord[k]]) return ord[k];
        return -1;
    endfunction

    // Reference touch: move id to the lowest rank
    task automatic model_touch(input int id);
        int tmp [3];
        int j = 0;
        for (int k = 0; k < 3; k++) if (ord[k] != id) begin tmp[j] = ord[k]; j++; end
        tmp[2] = id;
        ord = tmp;
    endtask

    // One granted transaction from idle or parked, ending with no request
    task automatic run_tx(input int mask, input int hold, input string tag);
        int w;
        req_i = mask[2:0];
        @(negedge clk);
        w = model_win(mask);
        chk(tag, grant_o, 1 << w);
        req_i = '0;
        for (int k = 0; k < hold; k++) begin
            cyc_end_i = 1'b1;
            seq_i  = (k % 2 == 0);
            lock_i = (k % 2 == 1);
            @(negedge clk);
            chk("R4 hold", grant_o, 1 << w);
        end
        cyc_end_i = 1'b1; seq_i = 1'b0; lock_i = 1'b0;
        @(negedge clk);
        cyc_end_i = 1'b0;
        model_touch(w);
        chk("R7 park", grant_o, 1 << w);
        chk("R7 negate", ctl_negate_o, 0);
    endtask

    initial begin
        int w;
        repeat (3) @(negedge clk);
        chk("R1 grant in reset", grant_o, 0);
        chk("R1 ack in reset", ext_ack_o, 0);
        chk("R1 negate in reset", ctl_negate_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 grant idle", grant_o, 0);
        chk("R1 negate idle", ctl_negate_o, 0);

        run_tx(7, 1, "R1 initial rank");
        for (int r = 0; r < 3; r++)
            for (int m = 1; m < 8; m++)
                run_tx(m, m % 3, (m == 7) ? "R3 rotation" : "R2 R8 winner");

        // External release from parked, then return to an internal master
        ext_req_i = 1'b1;
        @(negedge clk);
        chk("R5 negate phase", ctl_negate_o, 1);
        chk("R5 no ack yet", ext_ack_o, 0);
        chk("R5 grant off", grant_o, 0);
        @(negedge clk);
        chk("R5 ack", ext_ack_o, 1);
        chk("R5 negate held", ctl_negate_o, 1);
        repeat (3) begin
            @(negedge clk);
            chk("R6 ack held", ext_ack_o, 1);
        end
        ext_req_i = 1'b0;
        req_i = 3'b110;
        @(negedge clk);
        chk("R6 ack drop", ext_ack_o, 0);
        chk("R6 negate on return", ctl_negate_o, 1);
        chk("R6 grant gap", grant_o, 0);
        @(negedge clk);
        w = model_win(6);
        chk("R6 grant back", grant_o, 1 << w);
        chk("R6 negate off", ctl_negate_o, 0);
        req_i = '0;
        cyc_end_i = 1'b1;
        @(negedge clk);
        cyc_end_i = 1'b0;
        model_touch(w);
        chk("R7 park after return", grant_o, 1 << w);

        // External request raised inside a sequence and a lock
        req_i = 3'b001;
        @(negedge clk);
        chk("R8 grant", grant_o, 1);
        req_i = '0;
        ext_req_i = 1'b1;
        cyc_end_i = 1'b1; seq_i = 1'b1;
        @(negedge clk);
        chk("R4 seq blocks release", grant_o, 1);
        chk("R4 no negate in seq", ctl_negate_o, 0);
        seq_i = 1'b0; lock_i = 1'b1;
        @(negedge clk);
        chk("R4 lock blocks release", grant_o, 1);
        chk("R4 no ack in lock", ext_ack_o, 0);
        lock_i = 1'b0;
        @(negedge clk);
        cyc_end_i = 1'b0;
        model_touch(0);
        chk("R5 release at boundary", grant_o, 0);
        chk("R5 negate at boundary", ctl_negate_o, 1);
        @(negedge clk);
        chk("R5 ack after boundary", ext_ack_o, 1);
        ext_req_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R6 idle after return", grant_o, 0);
        chk("R6 controls live", ctl_negate_o, 0);

        // External and internal requests together
        ext_req_i = 1'b1;
        req_i = 3'b111;
        @(negedge clk);
        chk("R9 external wins", grant_o, 0);
        chk("R9 negate", ctl_negate_o, 1);
        @(negedge clk);
        chk("R9 ack", ext_ack_o, 1);
        ext_req_i = 1'b0;
        @(negedge clk);
        chk("R9 gap", grant_o, 0);
        @(negedge clk);
        w = model_win(7);
        chk("R9 internal after return", grant_o, 1 << w);
        req_i = '0;
        cyc_end_i = 1'b1;
        @(negedge clk);
        cyc_end_i = 1'b0;
        model_touch(w);

        for (int m = 1; m < 8; m++) run_tx(m, 0, "R3 final sweep");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule